// File: doc/BRIEF.md
# Winding Current Regulator with Comparator Feedback

This block holds the current in one stepper motor winding near a commanded level. Its only measurement is a single comparator bit that reads high when the winding current is above the command. It drives the high-side and low-side gate signals of one bridge leg, and the two are never on together. Each time the step sequencer signals a new step, the block conducts fully until the comparator first reports that the command has been reached. It then switches to pulse-width modulation. Once per PWM period it moves the duty one percent up or down, depending on whether the comparator was mostly high or mostly low during that period. The duty stays inside a fixed window.

The PWM period is split into a parameterized number of slots (100 by default, so one slot is one percent of duty), and each slot lasts a parameterized number of clocks. The default of 12 clocks per slot gives a 50 us period from a 24 MHz clock. When the high-side or low-side demand changes, both outputs are held off for a dead band of 24 clocks (1 us) by default. During full conduction the block watches for a feedback fault. If the comparator never goes high within a set number of PWM periods, the block treats feedback as missing, forces the duty to zero and switches off both gates until the next step.

Top module: `ccr_regulator`

## Requirements
- R1: After reset and until the first step pulse, `duty_o` is 0 and both gate outputs are low, whatever the comparator does.
- R2: A step pulse sets `duty_o` to 100 on the next clock, and after the dead band the high-side gate stays on with the low-side gate off.
- R3: The first time the synchronized comparator reads high during full conduction, the duty drops to 50 and a fresh PWM period begins.
- R4: At the end of each regulated PWM period, the comparator has been sampled once per slot. If it was high in more than half of those samples, the duty falls by 1. Otherwise the duty rises by 1.
- R5: The regulated duty never exceeds 80. A rise requested at 80 leaves it at 80.
- R6: The regulated duty never falls below 20. A fall requested at 20 leaves it at 20.
- R7: If the comparator stays low for NOFB_PERIODS full PWM periods of full conduction (4 by default), the duty becomes 0 and both gates stay off, whatever the comparator does, until the next step pulse.
- R8: The two gates are never both high. Each change of demand is followed by DEAD_CYCLES clocks with both gates off. At a steady duty D, the high side is therefore on for D*SLOT_CYCLES-DEAD_CYCLES clocks per period and the low side for (SLOTS-D)*SLOT_CYCLES-DEAD_CYCLES clocks.
- R9: A step pulse restarts full conduction from any state, including regulation and the feedback fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | One-clock pulse marking a new motor step |
| cmp_above_i | input | 1 | Comparator bit, 1 when winding current exceeds the command (asynchronous) |
| duty_o | output | $clog2(SLOTS+1) | Present duty in slots (percent by default) |
| gate_hi_o | output | 1 | High-side switch gate |
| gate_lo_o | output | 1 | Low-side switch gate |

## Verification
The hardest state to reach is the regulation window at its clamps. Hitting them takes dozens of consecutive PWM periods of one-sided comparator input, and the bench has to stay aligned with the period boundary, which the block restarts whenever it leaves full conduction. The bench therefore records the clock edge where regulation starts and changes the comparator level just after each following boundary. It then walks a table of level and period-count rows that push the duty up to 80, across the window and down to 20. The feedback fault is reached by holding the comparator low through four whole periods after a step. A second step then shows that the fault is cleared.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FULL  = 2'd1,
      ST_TRIM  = 2'd2,
      ST_FAULT = 2'd3
   } ccr_state_e;
endpackage

// File: rtl/ccr_slot_timer.sv
module ccr_slot_timer #(
   parameter int SLOTS       = 100,
   parameter int SLOT_CYCLES = 12,
   localparam int CYC_W  = $clog2(SLOT_CYCLES + 1),
   localparam int IDX_W  = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   output logic [IDX_W-1:0] slot_idx_o,
   output logic             slot_tick_o,
   output logic             period_end_o
);
   localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_CYCLES - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);

   logic [CYC_W-1:0] cyc_q;

   assign slot_tick_o  = (cyc_q == CYC_LAST);
   assign period_end_o = slot_tick_o && (slot_idx_o == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q      <= '0;
         slot_idx_o <= '0;
      end else if (restart_i) begin
         cyc_q      <= '0;
         slot_idx_o <= '0;
      end else if (slot_tick_o) begin
         cyc_q      <= '0;
         slot_idx_o <= period_end_o ? '0 : slot_idx_o + 1'b1;
      end else begin
         cyc_q <= cyc_q + 1'b1;
      end
   end
endmodule

// File: rtl/ccr_duty_ctrl.sv
module ccr_duty_ctrl
   import ccr_pkg::*;
#(
   parameter int SLOTS        = 100,
   parameter int DUTY_INIT    = 50,
   parameter int DUTY_MIN     = 20,
   parameter int DUTY_MAX     = 80,
   parameter int NOFB_PERIODS = 4,
   localparam int DUTY_W = $clog2(SLOTS + 1),
   localparam int TO_W   = $clog2(NOFB_PERIODS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              cmp_i,
   input  logic              slot_tick_i,
   input  logic              period_end_i,
   output logic              restart_o,
   output logic              drive_en_o,
   output logic [DUTY_W-1:0] duty_o
);
   localparam logic [DUTY_W-1:0] D_FULL = DUTY_W'(SLOTS);
   localparam logic [DUTY_W-1:0] D_INIT = DUTY_W'(DUTY_INIT);
   localparam logic [DUTY_W-1:0] D_MIN  = DUTY_W'(DUTY_MIN);
   localparam logic [DUTY_W-1:0] D_MAX  = DUTY_W'(DUTY_MAX);
   localparam logic [DUTY_W-1:0] HALF   = DUTY_W'(SLOTS / 2);
   localparam logic [TO_W-1:0]   TO_END = TO_W'(NOFB_PERIODS - 1);

   ccr_state_e        st_q;
   logic [DUTY_W-1:0] high_cnt_q;
   logic [DUTY_W-1:0] high_total;
   logic [TO_W-1:0]   to_cnt_q;

   assign high_total = high_cnt_q + DUTY_W'(cmp_i);
   assign restart_o  = step_i || (st_q == ST_FULL && cmp_i);
   assign drive_en_o = (st_q == ST_FULL) || (st_q == ST_TRIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         duty_o     <= '0;
         high_cnt_q <= '0;
         to_cnt_q   <= '0;
      end else if (step_i) begin
         st_q       <= ST_FULL;
         duty_o     <= D_FULL;
         high_cnt_q <= '0;
         to_cnt_q   <= '0;
      end else begin
         case (st_q)
            ST_FULL: begin
               if (cmp_i) begin
                  st_q       <= ST_TRIM;
                  duty_o     <= D_INIT;
                  high_cnt_q <= '0;
               end else if (period_end_i) begin
                  if (to_cnt_q == TO_END) begin
                     st_q   <= ST_FAULT;
                     duty_o <= '0;
                  end else begin
                     to_cnt_q <= to_cnt_q + 1'b1;
                  end
               end
            end
            ST_TRIM: begin
               if (period_end_i) begin
                  high_cnt_q <= '0;
                  if (high_total > HALF)
                     duty_o <= (duty_o > D_MIN) ? duty_o - 1'b1 : D_MIN;
                  else
                     duty_o <= (duty_o < D_MAX) ? duty_o + 1'b1 : D_MAX;
               end else if (slot_tick_i) begin
                  high_cnt_q <= high_total;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ccr_deadband.sv
module ccr_deadband #(
   parameter int DEAD_CYCLES = 24,
   localparam int DC_W = $clog2(DEAD_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic demand_i,
   output logic hi_o,
   output logic lo_o
);
   localparam logic [DC_W-1:0] DC_LOAD = DC_W'(DEAD_CYCLES);

   logic            side_q;
   logic [DC_W-1:0] dc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         side_q <= 1'b0;
         dc_q   <= DC_LOAD;
      end else if (!en_i || (demand_i != side_q)) begin
         side_q <= demand_i;
         dc_q   <= DC_LOAD;
      end else if (dc_q != '0) begin
         dc_q <= dc_q - 1'b1;
      end
   end

   assign hi_o = en_i &&  side_q && (dc_q == '0);
   assign lo_o = en_i && !side_q && (dc_q == '0);
endmodule

// File: rtl/ccr_regulator.sv
module ccr_regulator #(
   parameter int SLOTS        = 100,
   parameter int SLOT_CYCLES  = 12,
   parameter int DEAD_CYCLES  = 24,
   parameter int DUTY_INIT    = 50,
   parameter int DUTY_MIN     = 20,
   parameter int DUTY_MAX     = 80,
   parameter int NOFB_PERIODS = 4,
   parameter int SYNC_STAGES  = 2,
   localparam int DUTY_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              cmp_above_i,
   output logic [DUTY_W-1:0] duty_o,
   output logic              gate_hi_o,
   output logic              gate_lo_o
);
   if (SLOTS < 4)
      $error("SLOTS must be at least 4");
   if (SLOT_CYCLES < 1 || DEAD_CYCLES < 1 || NOFB_PERIODS < 1)
      $error("SLOT_CYCLES, DEAD_CYCLES and NOFB_PERIODS must be positive");
   if (!(DUTY_MIN >= 1 && DUTY_MIN <= DUTY_INIT && DUTY_INIT <= DUTY_MAX && DUTY_MAX < SLOTS))
      $error("duty window must satisfy 1 <= MIN <= INIT <= MAX < SLOTS");
   if (SYNC_STAGES < 0)
      $error("SYNC_STAGES must not be negative");

   logic              cmp_s;
   logic              restart;
   logic              drive_en;
   logic              slot_tick;
   logic              period_end;
   logic [DUTY_W-1:0] slot_idx;
   logic              demand;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign cmp_s = cmp_above_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q, cmp_above_i};
      end
      assign cmp_s = sync_q[SYNC_STAGES-1];
   end

   ccr_slot_timer #(.SLOTS(SLOTS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart_i(restart),
      .slot_idx_o(slot_idx), .slot_tick_o(slot_tick), .period_end_o(period_end)
   );

   ccr_duty_ctrl #(
      .SLOTS(SLOTS), .DUTY_INIT(DUTY_INIT), .DUTY_MIN(DUTY_MIN),
      .DUTY_MAX(DUTY_MAX), .NOFB_PERIODS(NOFB_PERIODS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .cmp_i(cmp_s),
      .slot_tick_i(slot_tick), .period_end_i(period_end),
      .restart_o(restart), .drive_en_o(drive_en), .duty_o(duty_o)
   );

   assign demand = drive_en && (slot_idx < duty_o);

   ccr_deadband #(.DEAD_CYCLES(DEAD_CYCLES)) u_dead (
      .clk(clk), .rst_n(rst_n), .en_i(drive_en), .demand_i(demand),
      .hi_o(gate_hi_o), .lo_o(gate_lo_o)
   );
endmodule

// File: rtl/ccr_regulator_chk.sv
module ccr_regulator_chk #(
   parameter int SLOTS    = 100,
   parameter int DUTY_MIN = 20,
   parameter int DUTY_MAX = 80,
   localparam int DUTY_W = $clog2(SLOTS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step_i,
   input logic [DUTY_W-1:0] duty_o,
   input logic              gate_hi_o,
   input logic              gate_lo_o
);
   function automatic bit in_win(input logic [DUTY_W-1:0] d);
      return (int'(d) >= DUTY_MIN) && (int'(d) <= DUTY_MAX);
   endfunction

   AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_o && gate_lo_o)); // R8
   AST_GAP_HI_LO: assert property (@(posedge clk) disable iff (!rst_n)
      gate_hi_o |=> !gate_lo_o); // R8
   AST_GAP_LO_HI: assert property (@(posedge clk) disable iff (!rst_n)
      gate_lo_o |=> !gate_hi_o); // R8
   AST_STEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |=> (int'(duty_o) == SLOTS)); // R2
   AST_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_o == '0) |-> (!gate_hi_o && !gate_lo_o)); // R7
   AST_DUTY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_o == '0) || (int'(duty_o) == SLOTS) || in_win(duty_o)); // R5
   AST_DUTY_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win($past(duty_o)) && in_win(duty_o)) |->
      ((int'(duty_o) - int'($past(duty_o)) <= 1) &&
       (int'($past(duty_o)) - int'(duty_o) <= 1))); // R4
endmodule

bind ccr_regulator ccr_regulator_chk #(
   .SLOTS(SLOTS), .DUTY_MIN(DUTY_MIN), .DUTY_MAX(DUTY_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .step_i(step_i), .duty_o(duty_o),
   .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
);

// File: tb/ccr_regulator_tb.sv
module ccr_regulator_tb;
   localparam int CLK_PERIOD = 10;
   localparam int SLOTS = 100;
   localparam int SC    = 2;
   localparam int DEAD  = 3;
   localparam int NOFB  = 4;
   localparam int SYNC  = 2;
   localparam int P     = SLOTS * SC;
   localparam int NROWS = 7;
   localparam int ROW_CMP [NROWS] = '{1, 0, 0, 1, 1, 0, 1};
   localparam int ROW_N   [NROWS] = '{3, 5, 30, 2, 62, 1, 3};
   localparam int ROW_EXP [NROWS] = '{47, 52, 80, 78, 20, 21, 20};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_i = 1'b0;
   logic       cmp_above_i = 1'b0;
   logic [6:0] duty_o;
   logic       gate_hi_o, gate_lo_o;
   int         checks = 0;
   int         errors = 0;
   int         overlap = 0;
   bit         done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ccr_regulator #(
      .SLOTS(SLOTS), .SLOT_CYCLES(SC), .DEAD_CYCLES(DEAD), .DUTY_INIT(50),
      .DUTY_MIN(20), .DUTY_MAX(80), .NOFB_PERIODS(NOFB), .SYNC_STAGES(SYNC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .cmp_above_i(cmp_above_i),
      .duty_o(duty_o), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
   );

   always @(negedge clk) if (rst_n && gate_hi_o && gate_lo_o) overlap++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic pulse_step();
      @(negedge clk) step_i = 1'b1;
      @(negedge clk) step_i = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      int hi_n, lo_n;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: idle after reset
      @(negedge clk);
      chk(duty_o == 0, "R1 idle duty", duty_o, 0);
      chk(!gate_hi_o && !gate_lo_o, "R1 idle gates", {gate_hi_o, gate_lo_o}, 0);
      for (int k = 0; k < 20; k++) @(negedge clk) cmp_above_i = k[0];
      cmp_above_i = 1'b0;
      repeat (5) @(negedge clk);
      chk(duty_o == 0 && !gate_hi_o && !gate_lo_o, "R1 idle ignores comparator", duty_o, 0);
      // R2: step gives full conduction
      pulse_step();
      repeat (10) @(negedge clk);
      chk(duty_o == 100, "R2 full duty", duty_o, 100);
      chk(gate_hi_o && !gate_lo_o, "R2 high side on", {gate_hi_o, gate_lo_o}, 2);
      // R3: comparator reaches command
      cmp_above_i = 1'b1;
      repeat (SYNC + 1) @(posedge clk);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(duty_o == 50, "R3 regulation start", duty_o, 50);
      // R4 R5 R6: table walk
      for (int i = 0; i < NROWS; i++) begin
         cmp_above_i = ROW_CMP[i][0];
         repeat (ROW_N[i] * P) @(posedge clk);
         @(negedge clk);
         chk(duty_o == ROW_EXP[i], (i == 2) ? "R5 clamp max" : (i == 4 || i == 6) ? "R6 clamp min" : "R4 duty walk",
             duty_o, ROW_EXP[i]);
      end
      // R8: on-time at steady duty 20
      hi_n = 0; lo_n = 0;
      for (int k = 0; k < P; k++) begin
         @(negedge clk);
         if (gate_hi_o) hi_n++;
         if (gate_lo_o) lo_n++;
      end
      chk(hi_n == 20 * SC - DEAD, "R8 high on-time", hi_n, 20 * SC - DEAD);
      chk(lo_n == 80 * SC - DEAD, "R8 low on-time", lo_n, 80 * SC - DEAD);
      // R9: step during regulation
      cmp_above_i = 1'b0;
      repeat (5) @(negedge clk);
      @(negedge clk) step_i = 1'b1;
      @(posedge clk);
      @(negedge clk) step_i = 1'b0;
      chk(duty_o == 100, "R9 step from regulation", duty_o, 100);
      repeat (9) @(negedge clk);
      chk(gate_hi_o && !gate_lo_o, "R2 high side after restart", {gate_hi_o, gate_lo_o}, 2);
      // R7: no feedback timeout (step edge was 10 cycles ago)
      repeat (NOFB * P - 15) @(posedge clk);
      @(negedge clk);
      chk(duty_o == 100, "R7 before timeout", duty_o, 100);
      repeat (10) @(posedge clk);
      @(negedge clk);
      chk(duty_o == 0, "R7 timeout duty", duty_o, 0);
      chk(!gate_hi_o && !gate_lo_o, "R7 gates off", {gate_hi_o, gate_lo_o}, 0);
      cmp_above_i = 1'b1;
      repeat (10) @(negedge clk);
      chk(duty_o == 0 && !gate_hi_o && !gate_lo_o, "R7 fault ignores comparator", duty_o, 0);
      // R9: step clears fault
      step_i = 1'b1;
      @(posedge clk);
      @(negedge clk) step_i = 1'b0;
      chk(duty_o == 100, "R9 step from fault", duty_o, 100);
      repeat (3) @(negedge clk);
      chk(duty_o == 50, "R3 immediate reach", duty_o, 50);
      chk(overlap == 0, "R8 no overlap", overlap, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule